// File: doc/BRIEF.md
# Sector-Multiplexed Queue Status Bus

This block carries per-queue threshold status for a multi-queue buffer over a narrow status bus. Each queue owns one status flag (almost-full on the producer side, almost-empty on the consumer side). There are more queues than bus bits, so the queues are grouped into sectors of bus-width size. The bus shows one sector at a time, and a companion output gives the number of the sector on the bus.

The block holds two identical scanners. The write-side scanner runs on the write clock and shows almost-full flags. The read-side scanner runs on the read clock and shows almost-empty flags. A single mode input applies to both scanners. In polled mode each scanner steps through every sector on its own clock, one sector per rising edge. In direct mode each scanner shows the sector that its own side selects. When the configured queue count fits in one sector, the bus is pinned to sector 0 and each bit maps to one queue. Bit positions that belong to unconfigured queues read as zero.

Each scanner is a small state machine with four states. `S_RESET` is held while reset is asserted. `S_FIXED` is taken when the queue count is at most the bus width. `S_SCAN` is taken in polled mode with more queues than bus bits. `S_ADDR` is taken in direct mode with more queues than bus bits. All transitions are evaluated on every rising edge. `S_RESET` leaves for whichever of the other three the inputs select. From any of `S_FIXED`, `S_SCAN` or `S_ADDR`, the machine can move directly to either of the others when the count or mode changes. Entering `S_SCAN` from any other state shows sector 0 first. Remaining in `S_SCAN` advances the sector.

Top module: `qflag_sector_bus`

## Requirements
- R1: While a side's reset is low, that side's bus reads 0 and its sector output reads 0. Mode, count, select and flag inputs have no effect during reset.
- R2: On the bus, bit b of sector s shows the flag of queue s*8+b, with queues numbered from 0. Sector 0 holds queues 0-7 and sector 1 holds queues 8-15. The sector output gives s. Both outputs are registered and change on the rising edge that samples the flags, count, mode and select.
- R3: In polled mode (poll_en=1) with queue_count above 8, the sector shown steps through the sectors as follows. The first edge in this condition shows sector 0. This applies after reset, after direct mode, and after a count of 8 or less. Each later edge advances the sector by one and wraps from 1 back to 0. Both sectors are cycled for every count from 9 to 16.
- R4: In direct mode (poll_en=0) with queue_count above 8, each edge shows the sector given by that side's select input.
- R5: A bus bit whose queue number s*8+b is not below queue_count reads 0, whatever its flag input.
- R6: When queue_count is 8 or less, every edge shows sector 0 in both modes, and the select input has no effect.
- R7: The write-side outputs change only on wr_clk and depend only on full_soon_flags and wr_sector_sel. The read-side outputs change only on rd_clk and depend only on empty_soon_flags and rd_sector_sel.
- R8: The single poll_en input sets polled or direct operation for both sides at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst_n | input | 1 | Write-side asynchronous reset, active low |
| rd_clk | input | 1 | Read-side clock |
| rd_rst_n | input | 1 | Read-side asynchronous reset, active low |
| poll_en | input | 1 | 1 = polled scanning, 0 = direct sector addressing (both sides) |
| queue_count | input | 5 | Number of configured queues, 1 to 16 |
| wr_sector_sel | input | 1 | Sector chosen for the write-side bus in direct mode |
| rd_sector_sel | input | 1 | Sector chosen for the read-side bus in direct mode |
| full_soon_flags | input | 16 | Per-queue almost-full flags, bit i = queue i |
| empty_soon_flags | input | 16 | Per-queue almost-empty flags, bit i = queue i |
| full_soon_bus | output | 8 | Almost-full status of the sector shown |
| full_soon_sector | output | 1 | Number of the sector on full_soon_bus |
| empty_soon_bus | output | 8 | Almost-empty status of the sector shown |
| empty_soon_sector | output | 1 | Number of the sector on empty_soon_bus |

## Verification
Every result is due one rising edge after the stimulus, on the clock that owns the side: inputs present at a rising edge appear on both outputs of that side just after that edge. The bench changes all inputs on falling edges of the write clock. It compares each side with its model on the falling edge of the side's own clock, which falls halfway between the edge that produced the result and the next edge. The read clock runs at half the write rate with a 2 ns offset, so no input ever changes on a read-side rising edge. A polled-mode toggle check on the read side spans exactly one read edge.

// File: rtl/qfsb_pkg.sv
package qfsb_pkg;

    // Scanner operating states
    typedef enum logic [1:0] {
        S_RESET = 2'd0,  // held while reset is asserted
        S_FIXED = 2'd1,  // queue count fits one sector: sector 0 pinned
        S_SCAN  = 2'd2,  // polled: advance one sector per edge
        S_ADDR  = 2'd3   // direct: sector taken from the select input
    } scan_state_e;

    function automatic int sectors_for(int queues, int width);
        return (queues + width - 1) / width;
    endfunction

    function automatic int sel_width(int sectors);
        return (sectors > 1) ? $clog2(sectors) : 1;
    endfunction

endpackage

// File: rtl/sector_mask.sv
module sector_mask
    import qfsb_pkg::*;
#(
    parameter int NUM_QUEUES = 16,
    parameter int BUS_W      = 8,
    localparam int NUM_SECT  = sectors_for(NUM_QUEUES, BUS_W),
    localparam int SEL_W     = sel_width(NUM_SECT),
    localparam int CNT_W     = $clog2(NUM_QUEUES + 1),
    localparam int PAD_W     = NUM_SECT * BUS_W
) (
    input  logic [NUM_QUEUES-1:0] flags,
    input  logic [SEL_W-1:0]      sector,
    input  logic [CNT_W-1:0]      queue_count,
    output logic [BUS_W-1:0]      bits
);

    logic [PAD_W-1:0] padded;
    logic [BUS_W-1:0] window;
    logic [BUS_W-1:0] live;

    assign padded = PAD_W'(flags);
    assign window = padded[int'(sector) * BUS_W +: BUS_W];

    // A bit is live only when its queue number is below the configured count
    always_comb begin
        for (int b = 0; b < BUS_W; b++) begin
            live[b] = ((int'(sector) * BUS_W + b) < int'(queue_count));
        end
    end

    assign bits = window & live;

endmodule

// File: rtl/sector_scanner.sv
module sector_scanner
    import qfsb_pkg::*;
#(
    parameter int NUM_QUEUES = 16,
    parameter int BUS_W      = 8,
    localparam int NUM_SECT  = sectors_for(NUM_QUEUES, BUS_W),
    localparam int SEL_W     = sel_width(NUM_SECT),
    localparam int CNT_W     = $clog2(NUM_QUEUES + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  poll_en,
    input  logic [CNT_W-1:0]      queue_count,
    input  logic [SEL_W-1:0]      sector_sel,
    input  logic [NUM_QUEUES-1:0] flags,
    output logic [BUS_W-1:0]      bus_o,
    output logic [SEL_W-1:0]      sector_o
);

    localparam logic [SEL_W-1:0] LAST = SEL_W'(NUM_SECT - 1);

    scan_state_e      state_q, state_d;
    logic [SEL_W-1:0] sec_d;
    logic [SEL_W-1:0] sel_clamped;
    logic [BUS_W-1:0] bits_d;

    assign sel_clamped = (int'(sector_sel) >= NUM_SECT) ? LAST : sector_sel;

    // Transition selection
    always_comb begin
        if (int'(queue_count) <= BUS_W) begin
            state_d = S_FIXED;
        end else if (poll_en) begin
            state_d = S_SCAN;
        end else begin
            state_d = S_ADDR;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    // Sector choice for the coming edge
    always_comb begin
        sec_d = '0;
        unique case (state_d)
            S_RESET: sec_d = '0;
            S_FIXED: sec_d = '0;
            S_SCAN: begin
                if (state_q != S_SCAN) begin
                    sec_d = '0;
                end else if (sector_o == LAST) begin
                    sec_d = '0;
                end else begin
                    sec_d = sector_o + 1'b1;
                end
            end
            S_ADDR:  sec_d = sel_clamped;
        endcase
    end

    sector_mask #(
        .NUM_QUEUES (NUM_QUEUES),
        .BUS_W      (BUS_W)
    ) u_mask (
        .flags       (flags),
        .sector      (sec_d),
        .queue_count (queue_count),
        .bits        (bits_d)
    );

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sector_o <= '0;
            bus_o    <= '0;
        end else begin
            sector_o <= sec_d;
            bus_o    <= bits_d;
        end
    end

    function automatic logic [BUS_W-1:0] live_bits(logic [SEL_W-1:0] s, logic [CNT_W-1:0] n);
        logic [BUS_W-1:0] m;
        for (int b = 0; b < BUS_W; b++) begin
            m[b] = ((int'(s) * BUS_W + b) < int'(n));
        end
        return m;
    endfunction

    // R3: staying in polled scanning advances and wraps the sector
    assert_poll_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SCAN && poll_en && int'(queue_count) > BUS_W)
        |=> (sector_o == (($past(sector_o) == LAST) ? '0 : $past(sector_o) + 1'b1)));

    // R4: direct addressing loads the selected sector
    assert_direct_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!poll_en && int'(queue_count) > BUS_W && int'(sector_sel) < NUM_SECT)
        |=> (sector_o == $past(sector_sel)));

    // R6: a count that fits one sector pins sector 0
    assert_single_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(queue_count) <= BUS_W) |=> (sector_o == '0));

    // R5: bits of unconfigured queues read zero
    assert_dead_bits_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((bus_o & ~live_bits(sector_o, $past(queue_count))) == '0));

endmodule

// File: rtl/qflag_sector_bus.sv
module qflag_sector_bus
    import qfsb_pkg::*;
#(
    parameter int NUM_QUEUES = 16,
    parameter int BUS_W      = 8,
    localparam int NUM_SECT  = sectors_for(NUM_QUEUES, BUS_W),
    localparam int SEL_W     = sel_width(NUM_SECT),
    localparam int CNT_W     = $clog2(NUM_QUEUES + 1)
) (
    input  logic                  wr_clk,
    input  logic                  wr_rst_n,
    input  logic                  rd_clk,
    input  logic                  rd_rst_n,
    input  logic                  poll_en,
    input  logic [CNT_W-1:0]      queue_count,
    input  logic [SEL_W-1:0]      wr_sector_sel,
    input  logic [SEL_W-1:0]      rd_sector_sel,
    input  logic [NUM_QUEUES-1:0] full_soon_flags,
    input  logic [NUM_QUEUES-1:0] empty_soon_flags,
    output logic [BUS_W-1:0]      full_soon_bus,
    output logic [SEL_W-1:0]      full_soon_sector,
    output logic [BUS_W-1:0]      empty_soon_bus,
    output logic [SEL_W-1:0]      empty_soon_sector
);

    // Write side: almost-full status on the write clock
    sector_scanner #(
        .NUM_QUEUES (NUM_QUEUES),
        .BUS_W      (BUS_W)
    ) u_wr_scan (
        .clk         (wr_clk),
        .rst_n       (wr_rst_n),
        .poll_en     (poll_en),
        .queue_count (queue_count),
        .sector_sel  (wr_sector_sel),
        .flags       (full_soon_flags),
        .bus_o       (full_soon_bus),
        .sector_o    (full_soon_sector)
    );

    // Read side: almost-empty status on the read clock
    sector_scanner #(
        .NUM_QUEUES (NUM_QUEUES),
        .BUS_W      (BUS_W)
    ) u_rd_scan (
        .clk         (rd_clk),
        .rst_n       (rd_rst_n),
        .poll_en     (poll_en),
        .queue_count (queue_count),
        .sector_sel  (rd_sector_sel),
        .flags       (empty_soon_flags),
        .bus_o       (empty_soon_bus),
        .sector_o    (empty_soon_sector)
    );

endmodule

// File: tb/qflag_sector_bus_bench.sv
module qflag_sector_bus_bench;

    localparam int CLK_PERIOD = 10;

    logic        wr_clk = 1'b0;
    logic        rd_clk = 1'b0;
    logic        wr_rst_n, rd_rst_n, poll_en;
    logic [4:0]  queue_count;
    logic [0:0]  wr_sector_sel, rd_sector_sel;
    logic [15:0] full_soon_flags, empty_soon_flags;
    logic [7:0]  full_soon_bus, empty_soon_bus;
    logic [0:0]  full_soon_sector, empty_soon_sector;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) wr_clk = ~wr_clk;
    initial begin
        #2;
        forever #(CLK_PERIOD) rd_clk = ~rd_clk;
    end

    qflag_sector_bus u_qflag_sector_bus (
        .wr_clk            (wr_clk),
        .wr_rst_n          (wr_rst_n),
        .rd_clk            (rd_clk),
        .rd_rst_n          (rd_rst_n),
        .poll_en           (poll_en),
        .queue_count       (queue_count),
        .wr_sector_sel     (wr_sector_sel),
        .rd_sector_sel     (rd_sector_sel),
        .full_soon_flags   (full_soon_flags),
        .empty_soon_flags  (empty_soon_flags),
        .full_soon_bus     (full_soon_bus),
        .full_soon_sector  (full_soon_sector),
        .empty_soon_bus    (empty_soon_bus),
        .empty_soon_sector (empty_soon_sector)
    );

    function automatic logic [7:0] live_of(int sec, int cnt);
        logic [7:0] m;
        for (int b = 0; b < 8; b++) m[b] = ((sec * 8 + b) < cnt);
        return m;
    endfunction

    function automatic logic [7:0] exp_bus(logic [15:0] f, int sec, int cnt);
        logic [7:0] r;
        for (int b = 0; b < 8; b++) r[b] = ((sec * 8 + b) < cnt) ? f[sec * 8 + b] : 1'b0;
        return r;
    endfunction

    function automatic string tag_of(bit in_rst, int cnt, bit poll);
        if (in_rst) return "R1";
        if (cnt <= 8) return "R6";
        if (poll) return "R3";
        return "R4";
    endfunction

    // Reference models, one per side, updated on that side's rising edge
    int         m_wsec = 0, m_rsec = 0, m_wcnt = 16, m_rcnt = 16;
    logic [7:0] m_wbus = '0, m_rbus = '0;
    bit         m_wpoll = 1'b0, m_rpoll = 1'b0;
    string      m_wtag = "R1", m_rtag = "R1";

    always @(posedge wr_clk) begin
        if (!wr_rst_n) begin
            m_wsec = 0; m_wbus = '0; m_wpoll = 1'b0; m_wtag = "R1";
        end else begin
            if (queue_count <= 8) begin
                m_wsec = 0; m_wpoll = 1'b0;
            end else if (poll_en) begin
                m_wsec = m_wpoll ? (m_wsec + 1) % 2 : 0; m_wpoll = 1'b1;
            end else begin
                m_wsec = int'(wr_sector_sel); m_wpoll = 1'b0;
            end
            m_wcnt = int'(queue_count);
            m_wbus = exp_bus(full_soon_flags, m_wsec, m_wcnt);
            m_wtag = tag_of(1'b0, m_wcnt, poll_en);
        end
    end

    always @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            m_rsec = 0; m_rbus = '0; m_rpoll = 1'b0; m_rtag = "R1";
        end else begin
            if (queue_count <= 8) begin
                m_rsec = 0; m_rpoll = 1'b0;
            end else if (poll_en) begin
                m_rsec = m_rpoll ? (m_rsec + 1) % 2 : 0; m_rpoll = 1'b1;
            end else begin
                m_rsec = int'(rd_sector_sel); m_rpoll = 1'b0;
            end
            m_rcnt = int'(queue_count);
            m_rbus = exp_bus(empty_soon_flags, m_rsec, m_rcnt);
            m_rtag = tag_of(1'b0, m_rcnt, poll_en);
        end
    end

    task automatic check_side(string side, string tag, int cnt, logic [7:0] gb, int gs,
                              logic [7:0] eb, int es);
        string t;
        checks++;
        t = tag;
        if (gb !== eb || gs != es) begin
            if (gs == es && (((gb ^ eb) & live_of(es, cnt)) == '0)) t = "R5";
            fails++;
            $display("FAIL %s %s side: bus=%h sector=%0d expected bus=%h sector=%0d (t=%0t)",
                     t, side, gb, gs, eb, es, $time);
        end
    endtask

    task automatic expect_val(string tag, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h (t=%0t)", tag, what, got, exp, $time);
        end
    endtask

    // Continuous comparison half a period after each rising edge
    always @(negedge wr_clk) if (!done)
        check_side("write", m_wtag, m_wcnt, full_soon_bus, int'(full_soon_sector), m_wbus, m_wsec);
    always @(negedge rd_clk) if (!done)
        check_side("read", m_rtag, m_rcnt, empty_soon_bus, int'(empty_soon_sector), m_rbus, m_rsec);

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog (all requirements): run still busy, expected completion");
            done = 1'b1;
            summary();
            $finish;
        end
    end

    initial begin
        int s0;
        void'($urandom(32'h5EED_0042));
        wr_rst_n = 1'b0; rd_rst_n = 1'b0;
        poll_en = 1'b1; queue_count = 5'd16;
        wr_sector_sel = 1'b1; rd_sector_sel = 1'b1;
        full_soon_flags = 16'hFFFF; empty_soon_flags = 16'hFFFF;

        // R1: outputs stay clear under reset despite active inputs
        repeat (4) @(negedge wr_clk);
        expect_val("R1", "write bus in reset", int'(full_soon_bus), 0);
        expect_val("R1", "write sector in reset", int'(full_soon_sector), 0);
        expect_val("R1", "read bus in reset", int'(empty_soon_bus), 0);
        expect_val("R1", "read sector in reset", int'(empty_soon_sector), 0);
        wr_rst_n = 1'b1; rd_rst_n = 1'b1;

        // R2: bit mapping of the upper and lower sectors
        poll_en = 1'b0; full_soon_flags = 16'hA55A; wr_sector_sel = 1'b1;
        @(negedge wr_clk);
        expect_val("R2", "upper sector bus", int'(full_soon_bus), 8'hA5);
        expect_val("R2", "upper sector number", int'(full_soon_sector), 1);
        wr_sector_sel = 1'b0;
        @(negedge wr_clk);
        expect_val("R2", "lower sector bus", int'(full_soon_bus), 8'h5A);

        // R7: each side follows only its own select and flags
        full_soon_flags = 16'h1234; empty_soon_flags = 16'hABCD;
        wr_sector_sel = 1'b0; rd_sector_sel = 1'b1;
        repeat (3) @(negedge wr_clk);
        expect_val("R7", "write bus", int'(full_soon_bus), 8'h34);
        expect_val("R7", "write sector", int'(full_soon_sector), 0);
        expect_val("R7", "read bus", int'(empty_soon_bus), 8'hAB);
        expect_val("R7", "read sector", int'(empty_soon_sector), 1);

        // R5: unconfigured queue bits read zero
        queue_count = 5'd11; full_soon_flags = 16'hFFFF; wr_sector_sel = 1'b1;
        @(negedge wr_clk);
        expect_val("R5", "11-queue upper sector", int'(full_soon_bus), 8'h07);

        // R6: small count pins sector 0 in both modes
        queue_count = 5'd5; poll_en = 1'b1;
        @(negedge wr_clk);
        expect_val("R6", "5-queue bus", int'(full_soon_bus), 8'h1F);
        @(negedge wr_clk);
        expect_val("R6", "5-queue sector held", int'(full_soon_sector), 0);
        queue_count = 5'd8; poll_en = 1'b0; wr_sector_sel = 1'b1;
        @(negedge wr_clk);
        expect_val("R6", "select ignored sector", int'(full_soon_sector), 0);
        expect_val("R6", "select ignored bus", int'(full_soon_bus), 8'hFF);

        // R3: entry at sector 0, advance, wrap
        queue_count = 5'd16; poll_en = 1'b1; full_soon_flags = 16'hF00F;
        @(negedge wr_clk);
        expect_val("R3", "poll entry sector", int'(full_soon_sector), 0);
        expect_val("R3", "poll entry bus", int'(full_soon_bus), 8'h0F);
        @(negedge wr_clk);
        expect_val("R3", "poll step bus", int'(full_soon_bus), 8'hF0);
        @(negedge wr_clk);
        expect_val("R3", "poll wrap sector", int'(full_soon_sector), 0);

        // R8: the same mode input also scans the read side
        repeat (3) @(negedge wr_clk);
        s0 = int'(empty_soon_sector);
        repeat (2) @(negedge wr_clk);
        expect_val("R8", "read side toggles in polled mode", int'(empty_soon_sector), 1 - s0);

        // Random phases, checked continuously against the models
        for (int p = 0; p < 40; p++) begin
            @(negedge wr_clk);
            queue_count = (($urandom % 3) == 0) ? 5'(1 + $urandom % 8) : 5'(9 + $urandom % 8);
            poll_en = 1'($urandom % 2);
            for (int c = 0; c < 30; c++) begin
                full_soon_flags  = 16'($urandom);
                empty_soon_flags = 16'($urandom);
                wr_sector_sel    = 1'($urandom % 2);
                rd_sector_sel    = 1'($urandom % 2);
                @(negedge wr_clk);
            end
        end

        repeat (4) @(negedge wr_clk);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule